// File: doc/BRIEF.md
# Sliding-Window Power Monitor with Protection Alarm

The block estimates short-term power on a stream of 16-bit two's-complement samples. Each accepted sample is reduced to its magnitude. The magnitude enters a running sum, and the magnitude that entered N samples earlier is taken out of it. The N samples are held in a circular delay line. The window sum is divided by N with rounding. An optional extra halving can be applied. The result is presented as the power estimate.

That estimate is compared against a programmable threshold. A registered alarm is raised while the estimate is strictly above the threshold. The comparison is only made once the window holds N fresh samples.

Disabling the block, or switching the window length, empties the window. The window then refills from zero.

Top module: `pwr_window_guard`

## Requirements
- R1: The magnitude of a sample is its absolute value. The code 0x8000 (-32768) saturates to 32767.
- R2: `win_sel` = 0 selects a 64-sample window and `win_sel` = 1 selects a 128-sample window. The sum is divided by that N.
- R3: The sum is a sliding window. Each accepted sample adds its magnitude and removes the magnitude accepted N samples earlier. Before the window is full, nothing is removed.
- R4: The rounded average is floor((sum + N/2) / N). Exact halves round up.
- R5: With `gain_shift` = 1, `avg_out` is the rounded average shifted right by one more bit, truncating. With `gain_shift` = 0, `avg_out` is the rounded average. `avg_out` follows the sum in the same cycle the sum updates.
- R6: `alarm` goes high one cycle after a cycle in which the window is full and `avg_out` > `thresh`. The comparison is unsigned and strict, so equality does not raise it.
- R7: Once high, `alarm` falls one cycle after a cycle in which `avg_out` <= `thresh`.
- R8: `en` low, or `win_sel` differing from the window length in use, clears the sum, the fill count and `alarm` on the next edge. After that, `alarm` stays low until N new samples have been accepted.
- R9: A sample is accepted only when `en` and `in_valid` are both high. Otherwise `avg_out` does not change. Samples offered while `en` is low leave `avg_out` at 0.
- R10: The window sum never exceeds N x 32767, so the 23-bit accumulator cannot wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Monitor enable; low clears the window |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 16 | Signed sample |
| win_sel | input | 1 | Window length: 0 = 64, 1 = 128 |
| gain_shift | input | 1 | Extra right shift of the average by one bit |
| thresh | input | 16 | Unsigned alarm threshold |
| avg_out | output | 16 | Rounded, gain-adjusted window average |
| alarm | output | 1 | Protection flag |

## Verification
The properties assume that `en`, `win_sel` and `in_valid` are sampled synchronously and are stable around the active edge. The bench therefore drives every input on the falling edge. The alarm-release property also relies on `thresh` and `gain_shift` being held while the alarm is being judged. The bench changes them only while the window is being cleared. Sample values cover the full signed range, including the saturating code. Window changes are made only while `in_valid` is low, so the clear and a new sample never collide in the stimulus.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
    localparam int SAMPLE_W = 16;
    localparam int MAG_W    = SAMPLE_W - 1;
    localparam int MAX_LOG  = 7;
    localparam int DEPTH    = 1 << MAX_LOG;
    localparam int ACC_W    = SAMPLE_W + MAX_LOG;

    typedef enum logic {WIN_SHORT = 1'b0, WIN_LONG = 1'b1} win_mode_e;

    typedef struct packed {
        logic             push;
        logic [MAG_W-1:0] mag;
    } mag_beat_t;

    // rounded division by the window length, then optional halving
    function automatic logic [SAMPLE_W-1:0] scaled_avg(
        input logic [ACC_W-1:0] sum,
        input win_mode_e        mode,
        input logic             halve
    );
        logic [ACC_W-1:0] r;
        if (mode == WIN_LONG)
            r = (sum + ACC_W'(DEPTH / 2)) >> MAX_LOG;
        else
            r = (sum + ACC_W'(DEPTH / 4)) >> (MAX_LOG - 1);
        if (halve)
            r = r >> 1;
        return r[SAMPLE_W-1:0];
    endfunction
endpackage

// File: rtl/pwg_magnitude.sv
module pwg_magnitude
    import pwg_pkg::*;
(
    input  logic [SAMPLE_W-1:0] sample,
    output logic [MAG_W-1:0]    mag
);
    logic [SAMPLE_W-1:0] negated;

    always_comb begin
        negated = (~sample) + 1'b1;
        if (!sample[SAMPLE_W-1])
            mag = sample[MAG_W-1:0];
        else if (negated[SAMPLE_W-1])
            mag = {MAG_W{1'b1}};        // most negative code saturates
        else
            mag = negated[MAG_W-1:0];
    end
endmodule

// File: rtl/pwg_delay_line.sv
module pwg_delay_line
    import pwg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  win_mode_e        mode,
    input  mag_beat_t        beat,
    output logic [MAG_W-1:0] leave_mag,
    output logic             full
);
    localparam int PTR_W = MAX_LOG;
    localparam int CNT_W = MAX_LOG + 1;

    logic [MAG_W-1:0] ring [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [CNT_W-1:0] fill;
    logic [CNT_W-1:0] win_len;

    assign win_len   = (mode == WIN_LONG) ? CNT_W'(DEPTH) : CNT_W'(DEPTH / 2);
    assign full      = (fill == win_len);
    assign leave_mag = full ? ring[wr_ptr] : '0;

    always_ff @(posedge clk) begin
        if (beat.push)
            ring[wr_ptr] <= beat.mag;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_ptr <= '0;
            fill   <= '0;
        end else if (beat.push) begin
            if (CNT_W'(wr_ptr) == win_len - 1'b1)
                wr_ptr <= '0;
            else
                wr_ptr <= wr_ptr + 1'b1;
            if (!full)
                fill <= fill + 1'b1;
        end
    end
endmodule

// File: rtl/pwg_accum.sv
module pwg_accum
    import pwg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  mag_beat_t        beat,
    input  logic [MAG_W-1:0] leave_mag,
    output logic [ACC_W-1:0] sum
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            sum <= '0;
        else if (beat.push)
            sum <= sum + ACC_W'(beat.mag) - ACC_W'(leave_mag);
    end
endmodule

// File: rtl/pwg_level_cmp.sv
module pwg_level_cmp
    import pwg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                full,
    input  win_mode_e           mode,
    input  logic                gain_shift,
    input  logic [ACC_W-1:0]    sum,
    input  logic [SAMPLE_W-1:0] thresh,
    output logic [SAMPLE_W-1:0] avg,
    output logic                alarm
);
    assign avg = scaled_avg(sum, mode, gain_shift);

    always_ff @(posedge clk) begin
        if (rst || clear)
            alarm <= 1'b0;
        else
            alarm <= full && (avg > thresh);
    end
endmodule

// File: rtl/pwr_window_guard.sv
module pwr_window_guard
    import pwg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic                win_sel,
    input  logic                gain_shift,
    input  logic [SAMPLE_W-1:0] thresh,
    output logic [SAMPLE_W-1:0] avg_out,
    output logic                alarm
);
    win_mode_e        win_q;
    logic             clear;
    logic [MAG_W-1:0] mag;
    logic [MAG_W-1:0] leave_mag;
    logic             win_full;
    logic [ACC_W-1:0] win_sum;
    mag_beat_t        beat;

    assign clear     = !en || (win_mode_e'(win_sel) != win_q);
    assign beat.push = en && in_valid && !clear;
    assign beat.mag  = mag;

    always_ff @(posedge clk) begin
        if (rst)
            win_q <= WIN_SHORT;
        else
            win_q <= win_mode_e'(win_sel);
    end

    pwg_magnitude u_mag (
        .sample (in_sample),
        .mag    (mag)
    );

    pwg_delay_line u_dly (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .mode      (win_q),
        .beat      (beat),
        .leave_mag (leave_mag),
        .full      (win_full)
    );

    pwg_accum u_acc (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .beat      (beat),
        .leave_mag (leave_mag),
        .sum       (win_sum)
    );

    pwg_level_cmp u_cmp (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .full       (win_full),
        .mode       (win_q),
        .gain_shift (gain_shift),
        .sum        (win_sum),
        .thresh     (thresh),
        .avg        (avg_out),
        .alarm      (alarm)
    );
endmodule

// File: rtl/pwg_checker.sv
module pwg_checker
    import pwg_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [SAMPLE_W-1:0] in_sample,
    input logic [SAMPLE_W-1:0] thresh,
    input logic [SAMPLE_W-1:0] avg_out,
    input logic                alarm,
    input logic                clear,
    input logic                full,
    input logic                win_long,
    input logic [MAG_W-1:0]    mag,
    input logic [ACC_W-1:0]    sum
);
    assert_sat_abs_R1: assert property (@(posedge clk) disable iff (rst)
        (in_sample == 16'h8000) |-> (mag == {MAG_W{1'b1}}));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        sum <= (win_long ? ACC_W'(DEPTH) : ACC_W'(DEPTH / 2)) * ACC_W'((1 << MAG_W) - 1));

    assert_alarm_raise_R6: assert property (@(posedge clk) disable iff (rst)
        (full && !clear && (avg_out > thresh)) |=> alarm);

    assert_alarm_release_R7: assert property (@(posedge clk) disable iff (rst)
        (avg_out <= thresh) |=> !alarm);

    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (rst)
        clear |=> (sum == '0 && !alarm));

    assert_alarm_needs_full_R8: assert property (@(posedge clk) disable iff (rst)
        !full |=> !alarm);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !clear) |=> $stable(sum));
endmodule

bind pwr_window_guard pwg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .thresh    (thresh),
    .avg_out   (avg_out),
    .alarm     (alarm),
    .clear     (clear),
    .full      (win_full),
    .win_long  (win_q == pwg_pkg::WIN_LONG),
    .mag       (mag),
    .sum       (win_sum)
);

// File: tb/sim_pwr_window_guard.sv
module sim_pwr_window_guard;
    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic        in_valid;
    logic [15:0] in_sample;
    logic        win_sel;
    logic        gain_shift;
    logic [15:0] thresh;
    logic [15:0] avg_out;
    logic        alarm;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pwr_window_guard u0 (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .win_sel    (win_sel),
        .gain_shift (gain_shift),
        .thresh     (thresh),
        .avg_out    (avg_out),
        .alarm      (alarm)
    );

    typedef struct packed {
        logic [15:0] a;
        logic [15:0] b;
        logic        win;
        logic        gain;
        logic [15:0] th;
        logic [15:0] cnt;
        logic [15:0] exp_avg;
        logic        exp_alarm;
    } vec_t;

    // alternating a/b samples after a clear; expected values worked out from the requirements
    localparam vec_t VECS [7] = '{
        '{16'd1000, 16'd1000, 1'b0, 1'b0, 16'd500,   16'd64,  16'd1000,  1'b1}, // R3 R6
        '{16'd1000, 16'd1001, 1'b0, 1'b0, 16'd2000,  16'd64,  16'd1001,  1'b0}, // R4 half rounds up
        '{16'h8000, 16'h8000, 1'b1, 1'b0, 16'd32766, 16'd128, 16'd32767, 1'b1}, // R1 R10
        '{16'hFFFB, 16'd4,    1'b1, 1'b0, 16'd4,     16'd128, 16'd5,     1'b1}, // R2 R4
        '{16'd1000, 16'd1000, 1'b0, 1'b1, 16'd499,   16'd64,  16'd500,   1'b1}, // R5
        '{16'd3,    16'd0,    1'b0, 1'b1, 16'd1,     16'd64,  16'd1,     1'b0}, // R5 R6 equality
        '{16'd100,  16'd100,  1'b1, 1'b0, 16'd10,    16'd100, 16'd78,    1'b0}  // R8 not full
    };

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] s);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = s;
    endtask

    task automatic push_n(input int n, input logic [15:0] s);
        for (int k = 0; k < n; k++) push(s);
    endtask

    // last sample captured, then one more edge so the alarm has settled
    task automatic settle();
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic restart(input logic w, input logic g, input logic [15:0] th);
        @(negedge clk);
        en         = 1'b0;
        in_valid   = 1'b0;
        win_sel    = w;
        gain_shift = g;
        thresh     = th;
        @(negedge clk);
        en = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL timeout (all requirements): actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; en = 1'b0; in_valid = 1'b0; in_sample = '0;
        win_sel = 1'b0; gain_shift = 1'b0; thresh = '0;
        repeat (3) @(negedge clk);
        check("R8 reset avg_out", avg_out, 0);
        check("R8 reset alarm", alarm, 0);
        rst = 1'b0;

        for (int i = 0; i < 7; i++) begin
            restart(VECS[i].win, VECS[i].gain, VECS[i].th);
            for (int k = 0; k < int'(VECS[i].cnt); k++)
                push((k % 2 == 0) ? VECS[i].a : VECS[i].b);
            settle();
            check($sformatf("R3 R4 R5 vec%0d avg_out", i), avg_out, VECS[i].exp_avg);
            check($sformatf("R6 R8 vec%0d alarm", i), alarm, VECS[i].exp_alarm);
        end

        // R1: -32767 and -32768 both give magnitude 32767
        restart(1'b1, 1'b0, 16'd0);
        push_n(64, 16'h8001);
        push_n(64, 16'h8000);
        settle();
        check("R1 R10 negative full scale", avg_out, 32767);

        // R3: sliding replacement of old samples
        restart(1'b0, 1'b0, 16'd2500);
        push_n(64, 16'd1000);
        settle();
        check("R3 filled window", avg_out, 1000);
        check("R6 below threshold", alarm, 0);
        push_n(32, 16'd3000);
        settle();
        check("R3 half replaced", avg_out, 2000);
        push_n(32, 16'd3000);
        settle();
        check("R3 fully replaced", avg_out, 3000);
        check("R6 alarm raised", alarm, 1);

        // R7: alarm holds while above, then releases
        push_n(8, 16'd0);
        settle();
        check("R4 R7 still above", avg_out, 2625);
        check("R7 alarm held", alarm, 1);
        push_n(24, 16'd0);
        settle();
        check("R7 dropped avg", avg_out, 1500);
        check("R7 alarm released", alarm, 0);

        // R9: idle cycles and disabled samples
        repeat (5) @(negedge clk);
        check("R9 idle hold", avg_out, 1500);
        @(negedge clk);
        en = 1'b0;
        push_n(10, 16'd5000);
        settle();
        check("R9 disabled samples ignored", avg_out, 0);

        // R8: window change mid-run clears and regates the alarm
        restart(1'b0, 1'b0, 16'd0);
        push_n(64, 16'd1000);
        settle();
        check("R8 alarm before switch", alarm, 1);
        @(negedge clk);
        win_sel = 1'b1;
        @(negedge clk);
        check("R8 switch clears avg_out", avg_out, 0);
        check("R8 switch clears alarm", alarm, 0);
        push_n(127, 16'd1000);
        settle();
        check("R8 alarm gated at N-1", alarm, 0);
        check("R2 R4 partial long window", avg_out, 992);
        push(16'd1000);
        settle();
        check("R8 alarm after N", alarm, 1);
        check("R2 long window avg_out", avg_out, 1000);

        // R2: 64 samples averaged over the 128 window
        restart(1'b1, 1'b0, 16'd0);
        push_n(64, 16'd1000);
        settle();
        check("R2 divide by 128", avg_out, 500);

        summary();
        $finish;
    end
endmodule